// File: doc/BRIEF.md
# Hybrid Two-Level Multi-Queue Packet Buffer

This block keeps several logical FIFO queues of fixed-size units. Each queue has a small on-chip staging area at its back, a wide, slow bulk store in the middle, and a small on-chip cache at its front. Units arrive at line rate, one per cycle, into the back area of their queue. When a queue has gathered a full block of B units there, the whole block goes to the bulk store as a single wide write, and that block holds data of one queue only. A scheduler asks for units one per cycle from the front caches, and each answer comes back one cycle after the request.

A periodic refill slot occurs once every PERIOD cycles. In that slot exactly one queue's front cache is topped up. The queue chosen is the one whose front cache has the largest deficit, meaning its capacity minus its occupancy. If the chosen queue has blocks in the bulk store, it receives its oldest block of B units. If its bulk store is empty, the partial contents of its back area move straight to the front, so short queues never wait for a full block. A request that finds the front cache empty gets no answer and sets a sticky underrun flag. Admission, dropping and the scheduler itself live outside the block.

Top module: `hyb_fifo_mgr`

## Requirements
- R1: After reset, deq_valid is 0 and underrun is 0.
- R2: Within each queue, units are returned in exactly the order they were enqueued, and no unit is lost or duplicated.
- R3: A request for a queue whose front cache holds at least one unit sets deq_valid, with the oldest unit on deq_unit, in the cycle after the request.
- R4: A request for a queue whose front cache is empty leaves deq_valid at 0 in the next cycle and sets underrun. underrun stays 1 until the next reset, even when later requests are served.
- R5: A queue with no block in the bulk store but with units in its back area can be refilled by a direct back-to-front move. Fewer than B units enqueued into an idle block become readable within two refill periods. The direct move is never used while the queue has a block in the bulk store.
- R6: In each refill slot, among the eligible queues, the one with the largest deficit (front capacity HCAP minus front occupancy) is refilled, and ties go to the lowest queue index. A queue is eligible if it has a bulk block and its deficit is at least B, or if it has no bulk block, a non-empty back area, and a deficit at least as large as its back-area count.
- R7: At most one refill happens per slot, slots are PERIOD cycles apart, and a front cache never holds more than HCAP units, even when more than HCAP units are queued.
- R8: After the block has been idle for several refill periods, a queue holding at most HCAP units can be read back on consecutive cycles with every request served.
- R9: With its front cache settled full, a queue can be read at one unit per cycle without underrun. This holds when a single queue is drained back to back, when all queues are drained round-robin, and when a queue is written and read in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | An arriving unit is present this cycle |
| enq_queue | input | $clog2(NQ) | Queue of the arriving unit |
| enq_unit | input | W | Arriving unit |
| deq_req | input | 1 | Scheduler requests one unit this cycle |
| deq_queue | input | $clog2(NQ) | Queue being requested |
| deq_valid | output | 1 | A requested unit is returned this cycle |
| deq_unit | output | W | Returned unit |
| underrun | output | 1 | Sticky flag: a request found its front cache empty |

## Verification
The bench builds the block with four queues of 8-bit units, blocks of B=4, a front capacity of 14 per queue, 16 bulk blocks per queue and a refill slot every 4 cycles. At this size, a sweep of every queue length from 1 to the front capacity exercises the direct back-to-front move, partial and exact block boundaries, and the case where a queue just fits its front cache. With 30 to 40 units per queue the bulk store fills several blocks deep, which makes the deficit arbiter decide under single-queue, round-robin and simultaneous read-and-write streams. The underrun flag is checked against an empty queue, followed by a served request and then a reset.

// File: rtl/hyb_pkg.sv
// Shared helpers for the hybrid multi-queue buffer.
// Assumes pointer arithmetic operands are already below the ring limit.
package hyb_pkg;

    // Advance a ring index by a step no larger than the ring length.
    function automatic int unsigned wrap_add(int unsigned base, int unsigned step, int unsigned lim);
        int unsigned s;
        s = base + step;
        if (s >= lim) s = s - lim;
        return s;
    endfunction

endpackage

// File: rtl/hyb_tail_stage.sv
// Back staging area: gathers arriving units per queue until a full block
// of B exists, then emits that block toward bulk storage in the same cycle.
// A drain request hands the partial contents of one queue to the front cache.
// Assumes B >= 2 and at most one arrival per cycle.
module hyb_tail_stage #(
    parameter int NQ = 4,
    parameter int W  = 8,
    parameter int B  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_en,
    input  logic [$clog2(NQ)-1:0]         in_q,
    input  logic [W-1:0]                  in_data,
    input  logic                          drain_en,
    input  logic [$clog2(NQ)-1:0]         drain_q,
    output logic [B*W-1:0]                drain_data,
    output logic                          flush_en,
    output logic [$clog2(NQ)-1:0]         flush_q,
    output logic [B*W-1:0]                flush_data,
    output logic [NQ-1:0][$clog2(B+1)-1:0] tcnt
);
    localparam int QW = $clog2(NQ);
    localparam int CW = $clog2(B+1);

    logic [W-1:0] tmem [NQ][B-1];
    logic         collide;

    // Decide whether the arrival completes a block or lands in a drained area.
    always_comb begin
        collide  = drain_en && (drain_q == in_q);
        flush_en = in_en && !collide && (tcnt[in_q] == CW'(B-1));
        flush_q  = in_q;
        for (int j = 0; j < B-1; j++) flush_data[j*W +: W] = tmem[in_q][j];
        flush_data[(B-1)*W +: W] = in_data;
        for (int j = 0; j < B-1; j++) drain_data[j*W +: W] = tmem[drain_q][j];
        drain_data[(B-1)*W +: W] = '0;
    end

    // Per-queue fill counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) tcnt[q] <= '0;
        end else begin
            if (drain_en) tcnt[drain_q] <= '0;
            if (in_en) begin
                if (collide)       tcnt[in_q] <= CW'(1);
                else if (flush_en) tcnt[in_q] <= '0;
                else               tcnt[in_q] <= tcnt[in_q] + CW'(1);
            end
        end
    end

    // Unit storage; an arrival into a drained queue restarts at slot 0.
    always_ff @(posedge clk) begin
        if (in_en && !flush_en) begin
            if (collide) tmem[in_q][0] <= in_data;
            else         tmem[in_q][tcnt[in_q]] <= in_data;
        end
    end

endmodule

// File: rtl/hyb_bulk_store.sv
// Behavioural wide bulk memory: one ring of BD blocks per queue, each block
// B units of a single queue. One block write and one block read per cycle at
// most; reads are only issued in refill slots by the caller.
// Assumes the caller never writes a full ring nor reads an empty one.
module hyb_bulk_store #(
    parameter int NQ = 4,
    parameter int W  = 8,
    parameter int B  = 4,
    parameter int BD = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            put_en,
    input  logic [$clog2(NQ)-1:0]           put_q,
    input  logic [B*W-1:0]                  put_data,
    input  logic                            take_en,
    input  logic [$clog2(NQ)-1:0]           take_q,
    output logic [B*W-1:0]                  take_data,
    output logic [NQ-1:0][$clog2(BD+1)-1:0] bcnt
);
    import hyb_pkg::*;
    localparam int QW  = $clog2(NQ);
    localparam int BPW = $clog2(BD);
    localparam int BCW = $clog2(BD+1);

    logic [B*W-1:0] mem [NQ][BD];
    logic [BPW-1:0] wp [NQ];
    logic [BPW-1:0] rp [NQ];
    logic [NQ-1:0][BCW-1:0] bcnt_nxt;

    // Oldest block of the queue being read.
    assign take_data = mem[take_q][rp[take_q]];

    // Next block counts per queue.
    always_comb begin
        for (int q = 0; q < NQ; q++)
            bcnt_nxt[q] = bcnt[q]
                        + ((put_en  && put_q  == QW'(q)) ? BCW'(1) : BCW'(0))
                        - ((take_en && take_q == QW'(q)) ? BCW'(1) : BCW'(0));
    end

    // Ring pointers and counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                wp[q]   <= '0;
                rp[q]   <= '0;
                bcnt[q] <= '0;
            end
        end else begin
            if (put_en)  wp[put_q]  <= BPW'(wrap_add(32'(wp[put_q]), 1, BD));
            if (take_en) rp[take_q] <= BPW'(wrap_add(32'(rp[take_q]), 1, BD));
            bcnt <= bcnt_nxt;
        end
    end

    // Block storage write.
    always_ff @(posedge clk) begin
        if (put_en) mem[put_q][wp[put_q]] <= put_data;
    end

endmodule

// File: rtl/hyb_head_cache.sv
// Front cache: one ring of HCAP units per queue. Accepts up to B units for one
// queue per cycle and serves one unit per cycle with a registered response.
// Assumes the caller never fills beyond HCAP.
module hyb_head_cache #(
    parameter int NQ   = 4,
    parameter int W    = 8,
    parameter int B    = 4,
    parameter int HCAP = 14
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fill_en,
    input  logic [$clog2(NQ)-1:0]             fill_q,
    input  logic [$clog2(B+1)-1:0]            fill_cnt,
    input  logic [B*W-1:0]                    fill_data,
    input  logic                              pop_en,
    input  logic [$clog2(NQ)-1:0]             pop_q,
    output logic                              out_valid,
    output logic [W-1:0]                      out_data,
    output logic                              miss,
    output logic [NQ-1:0][$clog2(HCAP+1)-1:0] occ
);
    import hyb_pkg::*;
    localparam int QW = $clog2(NQ);
    localparam int PW = $clog2(HCAP);
    localparam int OW = $clog2(HCAP+1);

    logic [W-1:0]  mem [NQ][HCAP];
    logic [PW-1:0] wp [NQ];
    logic [PW-1:0] rp [NQ];
    logic [PW-1:0] slot_idx [B];
    logic [NQ-1:0][OW-1:0] occ_nxt;
    logic          hit;

    // Request outcome and destination slots of an incoming fill.
    always_comb begin
        hit  = pop_en && (occ[pop_q] != '0);
        miss = pop_en && (occ[pop_q] == '0);
        for (int j = 0; j < B; j++)
            slot_idx[j] = PW'(wrap_add(32'(wp[fill_q]), j, HCAP));
        for (int q = 0; q < NQ; q++)
            occ_nxt[q] = occ[q]
                       + ((fill_en && fill_q == QW'(q)) ? OW'(fill_cnt) : OW'(0))
                       - ((hit && pop_q == QW'(q)) ? OW'(1) : OW'(0));
    end

    // Pointers, occupancy and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                wp[q] <= '0;
                rp[q] <= '0;
            end
            occ       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= hit;
            if (hit) begin
                out_data  <= mem[pop_q][rp[pop_q]];
                rp[pop_q] <= PW'(wrap_add(32'(rp[pop_q]), 1, HCAP));
            end
            if (fill_en) wp[fill_q] <= PW'(wrap_add(32'(wp[fill_q]), 32'(fill_cnt), HCAP));
            occ <= occ_nxt;
        end
    end

    // Unit storage write for the leading fill_cnt units of the block.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int j = 0; j < B; j++)
                if (j < int'(fill_cnt)) mem[fill_q][slot_idx[j]] <= fill_data[j*W +: W];
        end
    end

endmodule

// File: rtl/hyb_refill_arb.sv
// Refill arbiter: opens a slot every PERIOD cycles and grants the eligible
// queue with the largest front-cache deficit, lowest index on ties. A grant
// to a queue with an empty bulk ring is a direct back-to-front move.
// Assumes PERIOD >= 2.
module hyb_refill_arb #(
    parameter int NQ     = 4,
    parameter int B      = 4,
    parameter int HCAP   = 14,
    parameter int BD     = 16,
    parameter int PERIOD = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NQ-1:0][$clog2(HCAP+1)-1:0] occ,
    input  logic [NQ-1:0][$clog2(BD+1)-1:0]   bcnt,
    input  logic [NQ-1:0][$clog2(B+1)-1:0]    tcnt,
    output logic                              grant_en,
    output logic [$clog2(NQ)-1:0]             grant_q,
    output logic                              grant_byp
);
    localparam int QW  = $clog2(NQ);
    localparam int PCW = $clog2(PERIOD);

    logic [PCW-1:0] slot_cnt;
    logic           found;
    logic           from_bulk;
    logic           from_tail;
    int             def;
    int             best;

    // Slot timer.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_cnt <= '0;
        else        slot_cnt <= (slot_cnt == PCW'(PERIOD-1)) ? '0 : slot_cnt + PCW'(1);
    end

    // Largest-deficit search over eligible queues.
    always_comb begin
        found     = 1'b0;
        best      = 0;
        grant_q   = '0;
        grant_byp = 1'b0;
        def       = 0;
        from_bulk = 1'b0;
        from_tail = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            def       = HCAP - int'(occ[i]);
            from_bulk = (bcnt[i] != '0) && (def >= B);
            from_tail = (bcnt[i] == '0) && (tcnt[i] != '0) && (def >= int'(tcnt[i]));
            if ((from_bulk || from_tail) && (!found || def > best)) begin
                found     = 1'b1;
                best      = def;
                grant_q   = QW'(i);
                grant_byp = from_tail;
            end
        end
        grant_en = found && (slot_cnt == '0);
    end

endmodule

// File: rtl/hyb_fifo_mgr.sv
// Top of the hybrid multi-queue buffer: back staging area, bulk block store,
// front caches and the deficit-driven refill arbiter.
// Assumes NQ >= 2, B >= 2, PERIOD >= 2 and HCAP >= B; bulk depth BD must
// cover the deepest backlog the environment creates.
module hyb_fifo_mgr #(
    parameter int NQ     = 4,
    parameter int W      = 8,
    parameter int B      = 4,
    parameter int HCAP   = 14,
    parameter int BD     = 16,
    parameter int PERIOD = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enq_valid,
    input  logic [$clog2(NQ)-1:0] enq_queue,
    input  logic [W-1:0]          enq_unit,
    input  logic                  deq_req,
    input  logic [$clog2(NQ)-1:0] deq_queue,
    output logic                  deq_valid,
    output logic [W-1:0]          deq_unit,
    output logic                  underrun
);
    localparam int QW  = $clog2(NQ);
    localparam int CW  = $clog2(B+1);
    localparam int OW  = $clog2(HCAP+1);
    localparam int BCW = $clog2(BD+1);

    logic [NQ-1:0][OW-1:0]  head_occ;
    logic [NQ-1:0][BCW-1:0] bulk_cnt;
    logic [NQ-1:0][CW-1:0]  tail_cnt;
    logic                   grant_en;
    logic [QW-1:0]          grant_q;
    logic                   grant_byp;
    logic                   flush_en;
    logic [QW-1:0]          flush_q;
    logic [B*W-1:0]         flush_data;
    logic [B*W-1:0]         bulk_data;
    logic [B*W-1:0]         tail_data;
    logic [B*W-1:0]         fill_data;
    logic [CW-1:0]          fill_cnt;
    logic                   miss;

    hyb_tail_stage #(.NQ(NQ), .W(W), .B(B)) u_tail (
        .clk(clk), .rst_n(rst_n),
        .in_en(enq_valid), .in_q(enq_queue), .in_data(enq_unit),
        .drain_en(grant_en && grant_byp), .drain_q(grant_q), .drain_data(tail_data),
        .flush_en(flush_en), .flush_q(flush_q), .flush_data(flush_data),
        .tcnt(tail_cnt)
    );

    hyb_bulk_store #(.NQ(NQ), .W(W), .B(B), .BD(BD)) u_bulk (
        .clk(clk), .rst_n(rst_n),
        .put_en(flush_en), .put_q(flush_q), .put_data(flush_data),
        .take_en(grant_en && !grant_byp), .take_q(grant_q), .take_data(bulk_data),
        .bcnt(bulk_cnt)
    );

    hyb_refill_arb #(.NQ(NQ), .B(B), .HCAP(HCAP), .BD(BD), .PERIOD(PERIOD)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .occ(head_occ), .bcnt(bulk_cnt), .tcnt(tail_cnt),
        .grant_en(grant_en), .grant_q(grant_q), .grant_byp(grant_byp)
    );

    // Refill source select: whole bulk block or partial back-area contents.
    always_comb begin
        fill_data = grant_byp ? tail_data : bulk_data;
        fill_cnt  = grant_byp ? tail_cnt[grant_q] : CW'(B);
    end

    hyb_head_cache #(.NQ(NQ), .W(W), .B(B), .HCAP(HCAP)) u_head (
        .clk(clk), .rst_n(rst_n),
        .fill_en(grant_en), .fill_q(grant_q), .fill_cnt(fill_cnt), .fill_data(fill_data),
        .pop_en(deq_req), .pop_q(deq_queue),
        .out_valid(deq_valid), .out_data(deq_unit), .miss(miss),
        .occ(head_occ)
    );

    // Sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    underrun <= 1'b0;
        else if (miss) underrun <= 1'b1;
    end

endmodule

// File: rtl/hyb_fifo_mgr_chk.sv
// Property checker for hyb_fifo_mgr, attached by bind below.
module hyb_fifo_mgr_chk #(
    parameter int NQ     = 4,
    parameter int B      = 4,
    parameter int HCAP   = 14,
    parameter int BD     = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              deq_req,
    input logic [$clog2(NQ)-1:0]             deq_queue,
    input logic                              deq_valid,
    input logic                              underrun,
    input logic [NQ-1:0][$clog2(HCAP+1)-1:0] head_occ,
    input logic [NQ-1:0][$clog2(BD+1)-1:0]   bulk_cnt,
    input logic [NQ-1:0][$clog2(B+1)-1:0]    tail_cnt,
    input logic                              grant_en,
    input logic [$clog2(NQ)-1:0]             grant_q,
    input logic                              grant_byp
);
    int dsel;
    assign dsel = HCAP - int'(head_occ[grant_q]);

    // R4
    miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && head_occ[deq_queue] == '0) |=> (underrun && !deq_valid));
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    // R3
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && head_occ[deq_queue] != '0) |=> deq_valid);
    // R7
    refill_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_en |=> !grant_en);
    // R5
    bypass_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_en && grant_byp) |-> (bulk_cnt[grant_q] == '0));

    for (genvar i = 0; i < NQ; i++) begin : g_q
        int  di;
        logic el;
        assign di = HCAP - int'(head_occ[i]);
        assign el = ((bulk_cnt[i] != '0) && (di >= B)) ||
                    ((bulk_cnt[i] == '0) && (tail_cnt[i] != '0) && (di >= int'(tail_cnt[i])));
        // R7
        occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(head_occ[i]) <= HCAP);
        // R6
        pick_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_en && el) |-> (dsel >= di));
        // R6
        pick_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_en && el && dsel == di) |-> (int'(grant_q) <= i));
    end

endmodule

bind hyb_fifo_mgr hyb_fifo_mgr_chk #(.NQ(NQ), .B(B), .HCAP(HCAP), .BD(BD)) chk (
    .clk(clk), .rst_n(rst_n),
    .deq_req(deq_req), .deq_queue(deq_queue), .deq_valid(deq_valid), .underrun(underrun),
    .head_occ(head_occ), .bulk_cnt(bulk_cnt), .tail_cnt(tail_cnt),
    .grant_en(grant_en), .grant_q(grant_q), .grant_byp(grant_byp)
);

// File: tb/hyb_fifo_mgr_test.sv
// Bench: reference queues in the bench predict every returned unit.
module hyb_fifo_mgr_test;
    localparam int NQ = 4, W = 8, B = 4, HCAP = 14, BD = 16, PERIOD = 4;
    localparam int QW = $clog2(NQ);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic [QW-1:0] enq_queue = '0;
    logic [W-1:0]  enq_unit = '0;
    logic          deq_req = 1'b0;
    logic [QW-1:0] deq_queue = '0;
    logic          deq_valid;
    logic [W-1:0]  deq_unit;
    logic          underrun;

    always #5 clk = ~clk;

    hyb_fifo_mgr #(.NQ(NQ), .W(W), .B(B), .HCAP(HCAP), .BD(BD), .PERIOD(PERIOD)) uut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_queue(enq_queue), .enq_unit(enq_unit),
        .deq_req(deq_req), .deq_queue(deq_queue),
        .deq_valid(deq_valid), .deq_unit(deq_unit), .underrun(underrun)
    );

    int total = 0;
    int bad = 0;
    logic [W-1:0] refq [NQ][256];
    int rh [NQ];
    int rt [NQ];
    logic [W-1:0] seq = 8'h11;

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; enq_valid = 1'b0; deq_req = 1'b0;
        for (int q = 0; q < NQ; q++) begin rh[q] = 0; rt[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(deq_valid == 1'b0, "R1 deq_valid", int'(deq_valid), 0);
        check(underrun == 1'b0, "R1 underrun", int'(underrun), 0);
    endtask

    // One cycle: optional enqueue and request; response checked one cycle later.
    task automatic step(bit we, int wq, bit re, int rq, string req);
        bit exp_hit;
        logic [W-1:0] exp_d;
        exp_hit = 1'b0;
        exp_d = '0;
        enq_valid = we; enq_queue = QW'(wq); enq_unit = seq;
        deq_req = re; deq_queue = QW'(rq);
        if (re && rh[rq] != rt[rq]) begin
            exp_hit = 1'b1;
            exp_d = refq[rq][rh[rq] % 256];
            rh[rq]++;
        end
        if (we) begin
            refq[wq][rt[wq] % 256] = seq;
            rt[wq]++;
            seq = seq + 8'd37;
        end
        @(negedge clk);
        enq_valid = 1'b0; deq_req = 1'b0;
        if (re) begin
            check(deq_valid == exp_hit, req, int'(deq_valid), int'(exp_hit));
            if (exp_hit && deq_valid)
                check(deq_unit == exp_d, "R2 order", int'(deq_unit), int'(exp_d));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // Sweep queue length 1..HCAP on rotating queues (R5 below B, R8 otherwise)
        for (int n = 1; n <= HCAP; n++) begin
            for (int k = 0; k < n; k++) step(1'b1, n % NQ, 1'b0, 0, "");
            idle(80);
            for (int k = 0; k < n; k++) step(1'b0, 0, 1'b1, n % NQ, (n < B) ? "R5 bypass" : "R8 settled");
            check(underrun == 1'b0, "R4 no false flag", int'(underrun), 0);
        end

        // Interleaved writes, reverse-order drains (R2, R3)
        for (int k = 0; k < 10; k++)
            for (int q = 0; q < NQ; q++) step(1'b1, q, 1'b0, 0, "");
        idle(60);
        for (int q = NQ-1; q >= 0; q--)
            for (int k = 0; k < 10; k++) step(1'b0, 0, 1'b1, q, "R3 hit");

        // Deep single queue drained back to back (R6 arbiter keeps up)
        do_reset();
        for (int k = 0; k < 40; k++) step(1'b1, 2, 1'b0, 0, "");
        idle(120);
        for (int k = 0; k < 40; k++) step(1'b0, 0, 1'b1, 2, "R6 single stream");
        check(underrun == 1'b0, "R9 single stream", int'(underrun), 0);

        // More than HCAP units in one queue: bounded front, nothing lost (R7)
        for (int k = 0; k < 30; k++) step(1'b1, 3, 1'b0, 0, "");
        idle(100);
        for (int k = 0; k < 30; k++) step(1'b0, 0, 1'b1, 3, "R7 overflow-free");

        // All queues deep, round-robin drain (R9)
        do_reset();
        for (int k = 0; k < 40; k++)
            for (int q = 0; q < NQ; q++) step(1'b1, q, 1'b0, 0, "");
        idle(200);
        for (int k = 0; k < 40; k++)
            for (int q = 0; q < NQ; q++) step(1'b0, 0, 1'b1, q, "R9 round robin");
        check(underrun == 1'b0, "R9 round robin flag", int'(underrun), 0);

        // Simultaneous write and read on one queue (R9), then drain remainder
        do_reset();
        for (int k = 0; k < 12; k++) step(1'b1, 1, 1'b0, 0, "");
        idle(60);
        for (int k = 0; k < 60; k++) step(1'b1, 1, 1'b1, 1, "R9 write+read");
        idle(60);
        for (int k = 0; k < 12; k++) step(1'b0, 0, 1'b1, 1, "R2 remainder");
        check(underrun == 1'b0, "R9 write+read flag", int'(underrun), 0);

        // Empty read, sticky flag, then reset clears it (R4, R1)
        do_reset();
        step(1'b0, 0, 1'b1, 0, "R4 empty read");
        check(underrun == 1'b1, "R4 flag set", int'(underrun), 1);
        step(1'b1, 0, 1'b0, 0, "");
        step(1'b1, 0, 1'b0, 0, "");
        idle(40);
        step(1'b0, 0, 1'b1, 0, "R3 after miss");
        step(1'b0, 0, 1'b1, 0, "R3 after miss");
        check(underrun == 1'b1, "R4 flag sticky", int'(underrun), 1);
        do_reset();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule